// File: doc/BRIEF.md
# FMA Special-Operand Result Resolver

This combinational block sits at the front of a single-precision fused multiply-add unit that computes z + x*y. It sorts each of the three operand words into one of six classes and decides whether the final answer is already known from those classes alone. When it is, the block gives the finished result word, marks it valid, and says whether an invalid-operation exception is raised. When it is not, it drops the valid bit so the arithmetic datapath takes over. In both cases the per-operand class codes go to that datapath.

Inside, the decision is a single enumerated resolution kind picked by a fixed-priority selector. The kinds are: `RK_SNAN_Z` (signaling addend), `RK_SNAN_X` and `RK_SNAN_Y` (signaling multiplicand), `RK_QNAN_X` and `RK_QNAN_Y` (quiet multiplicand), `RK_INFZ_PASS` and `RK_INFZ_INVALID` (infinity times zero), `RK_PROD_INF` (infinite product), `RK_PASS_Z` (addend passed through unchanged), `RK_ADDEND_INF` (infinite addend wins) and `RK_DATAPATH` (arithmetic needed). The selector moves down this list and stops at the first kind whose condition holds. The result builder then turns the chosen kind into output words. The block holds no state.

Top module: `fma_special_resolver`

## Requirements
- R1: Each operand is classified from its 8-bit exponent (bits 30:23) and 23-bit mantissa (bits 22:0). The class codes are ZERO=0 (exponent 0, mantissa 0), NORM=1 (exponent 1 to 254), DNORM=2 (exponent 0, mantissa nonzero), INF=3 (exponent 255, mantissa 0), QNAN=4 (exponent 255, mantissa bit 22 set) and SNAN=5 (exponent 255, bit 22 clear, mantissa nonzero). The codes appear on cls_x, cls_y and cls_z.
- R2: A signaling-NaN addend has the highest priority, whatever x and y are. It gives valid=1 and invalid=1, and the result is the addend quieted: mantissa bit 22 is set, and the sign and all other bits are kept.
- R3: If the addend is not signaling and x is a signaling NaN, the result is x quieted. Otherwise, if y is a signaling NaN, the result is y quieted, whatever the class of x. Both cases raise invalid.
- R4: If neither multiplicand is signaling and x is a quiet NaN, x is returned unchanged. Otherwise, if y is a quiet NaN, y is returned unchanged. Invalid is clear in both cases, and both beat a quiet-NaN addend.
- R5: If one multiplicand is infinity and the other is zero, a quiet-NaN addend is returned unchanged with invalid clear. Any other addend gives the default NaN 0x7FC00000 with invalid set.
- R6: An infinite product is infinity times a nonzero value, or infinity times infinity. With a non-NaN addend it gives an infinity with sign x[31] XOR y[31] and invalid clear, even when the addend is an infinity of the opposite sign. With a quiet-NaN addend it gives that addend.
- R7: A zero product (zero times zero, normal or denormal) with an infinite addend gives infinity with the addend's sign. With any other addend it returns the addend word unchanged, a denormal addend included.
- R8: A finite nonzero product returns a quiet-NaN addend unchanged, and turns an infinite addend into infinity with the addend's sign. Invalid is clear in both cases.
- R9: A finite nonzero product with a zero, normal or denormal addend gives valid=0, result word 0 and invalid=0.
- R10: A denormal multiplicand counts as a finite nonzero value: it is never treated as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_x | input | 32 | Multiplicand x |
| opnd_y | input | 32 | Multiplicand y |
| opnd_z | input | 32 | Addend z |
| spec_valid | output | 1 | The result word is final; the datapath is not needed |
| spec_word | output | 32 | Special result word (0 when spec_valid is low) |
| spec_invalid | output | 1 | Invalid-operation exception |
| cls_x | output | 3 | Class code of x |
| cls_y | output | 3 | Class code of y |
| cls_z | output | 3 | Class code of z |

## Verification
The bench builds the resolver with its default parameters: an 8-bit exponent and a 23-bit mantissa, which is the single-precision layout. At this size the hand-picked corner words are reachable directly: the quiet bit at position 22, the default NaN 0x7FC00000 and the all-ones exponent 255. A class-driven random generator supplies every one of the 216 class triples many times, with random signs and payloads. This brings every priority clash into play, such as a signaling addend against signaling multiplicands, or infinity times zero against a quiet addend.

// File: rtl/fma_rsv_pkg.sv
package fma_rsv_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO  = 3'd0,
        CLS_NORM  = 3'd1,
        CLS_DNORM = 3'd2,
        CLS_INF   = 3'd3,
        CLS_QNAN  = 3'd4,
        CLS_SNAN  = 3'd5
    } op_class_e;

    typedef enum logic [3:0] {
        RK_SNAN_Z       = 4'd0,
        RK_SNAN_X       = 4'd1,
        RK_SNAN_Y       = 4'd2,
        RK_QNAN_X       = 4'd3,
        RK_QNAN_Y       = 4'd4,
        RK_INFZ_PASS    = 4'd5,
        RK_INFZ_INVALID = 4'd6,
        RK_PROD_INF     = 4'd7,
        RK_PASS_Z       = 4'd8,
        RK_ADDEND_INF   = 4'd9,
        RK_DATAPATH     = 4'd10
    } res_kind_e;

    localparam int NUM_OPS = 3;
    localparam int OP_X    = 0;
    localparam int OP_Y    = 1;
    localparam int OP_Z    = 2;

endpackage

// File: rtl/fma_opnd_classify.sv
module fma_opnd_classify
    import fma_rsv_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic [WORD_W-1:0] word_i,
    output op_class_e         cls_o
);
    localparam int MAN_MSB = MAN_W - 1;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;
    logic             exp_zero;
    logic             exp_ones;
    logic             man_zero;
    logic             sign_unused;

    assign sign_unused = word_i[WORD_W-1];
    assign exp_f       = word_i[WORD_W-2:MAN_W];
    assign man_f       = word_i[MAN_W-1:0];
    assign exp_zero    = (exp_f == '0);
    assign exp_ones    = (exp_f == '1);
    assign man_zero    = (man_f == '0);

    always_comb begin
        if (exp_zero) begin
            cls_o = man_zero ? CLS_ZERO : CLS_DNORM;
        end else if (exp_ones) begin
            if (man_zero)
                cls_o = CLS_INF;
            else if (man_f[MAN_MSB])
                cls_o = CLS_QNAN;
            else
                cls_o = CLS_SNAN;
        end else begin
            cls_o = CLS_NORM;
        end
    end

endmodule

// File: rtl/fma_case_select.sv
module fma_case_select
    import fma_rsv_pkg::*;
(
    input  op_class_e cls_x_i,
    input  op_class_e cls_y_i,
    input  op_class_e cls_z_i,
    output res_kind_e kind_o
);
    logic x_inf, y_inf, x_zero, y_zero;
    logic inf_times_zero, prod_inf, prod_zero;
    logic z_qnan, z_inf;

    assign x_inf  = (cls_x_i == CLS_INF);
    assign y_inf  = (cls_y_i == CLS_INF);
    assign x_zero = (cls_x_i == CLS_ZERO);
    assign y_zero = (cls_y_i == CLS_ZERO);
    assign z_qnan = (cls_z_i == CLS_QNAN);
    assign z_inf  = (cls_z_i == CLS_INF);

    assign inf_times_zero = (x_inf && y_zero) || (x_zero && y_inf);
    assign prod_inf       = x_inf || y_inf;
    assign prod_zero      = x_zero || y_zero;

    // Fixed priority: the first matching condition decides the kind.
    always_comb begin
        if (cls_z_i == CLS_SNAN)
            kind_o = RK_SNAN_Z;
        else if (cls_x_i == CLS_SNAN)
            kind_o = RK_SNAN_X;
        else if (cls_y_i == CLS_SNAN)
            kind_o = RK_SNAN_Y;
        else if (cls_x_i == CLS_QNAN)
            kind_o = RK_QNAN_X;
        else if (cls_y_i == CLS_QNAN)
            kind_o = RK_QNAN_Y;
        else if (inf_times_zero)
            kind_o = z_qnan ? RK_INFZ_PASS : RK_INFZ_INVALID;
        else if (prod_inf)
            kind_o = z_qnan ? RK_PASS_Z : RK_PROD_INF;
        else if (prod_zero)
            kind_o = z_inf ? RK_ADDEND_INF : RK_PASS_Z;
        else if (z_qnan)
            kind_o = RK_PASS_Z;
        else if (z_inf)
            kind_o = RK_ADDEND_INF;
        else
            kind_o = RK_DATAPATH;
    end

endmodule

// File: rtl/fma_result_build.sv
module fma_result_build
    import fma_rsv_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  res_kind_e         kind_i,
    input  logic [WORD_W-1:0] x_i,
    input  logic [WORD_W-1:0] y_i,
    input  logic [WORD_W-1:0] z_i,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o,
    output logic              invalid_o
);
    localparam logic [WORD_W-1:0] QUIET_BIT   = WORD_W'(1) << (MAN_W - 1);
    localparam logic [WORD_W-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    function automatic logic [WORD_W-1:0] make_inf(input logic sgn);
        return {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    endfunction

    logic prod_sign;
    logic z_sign;

    assign prod_sign = x_i[WORD_W-1] ^ y_i[WORD_W-1];
    assign z_sign    = z_i[WORD_W-1];

    always_comb begin
        valid_o   = 1'b1;
        invalid_o = 1'b0;
        word_o    = '0;
        unique case (kind_i)
            RK_SNAN_Z: begin
                word_o    = z_i | QUIET_BIT;
                invalid_o = 1'b1;
            end
            RK_SNAN_X: begin
                word_o    = x_i | QUIET_BIT;
                invalid_o = 1'b1;
            end
            RK_SNAN_Y: begin
                word_o    = y_i | QUIET_BIT;
                invalid_o = 1'b1;
            end
            RK_QNAN_X:       word_o = x_i;
            RK_QNAN_Y:       word_o = y_i;
            RK_INFZ_PASS:    word_o = z_i;
            RK_INFZ_INVALID: begin
                word_o    = DEFAULT_NAN;
                invalid_o = 1'b1;
            end
            RK_PROD_INF:     word_o = make_inf(prod_sign);
            RK_PASS_Z:       word_o = z_i;
            RK_ADDEND_INF:   word_o = make_inf(z_sign);
            RK_DATAPATH:     valid_o = 1'b0;
            default: begin
                valid_o = 1'b0;
                word_o  = '0;
            end
        endcase
    end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fma_rsv_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input  logic [WORD_W-1:0] opnd_x,
    input  logic [WORD_W-1:0] opnd_y,
    input  logic [WORD_W-1:0] opnd_z,
    output logic              spec_valid,
    output logic [WORD_W-1:0] spec_word,
    output logic              spec_invalid,
    output logic [2:0]        cls_x,
    output logic [2:0]        cls_y,
    output logic [2:0]        cls_z
);
    logic [WORD_W-1:0] words [NUM_OPS];
    op_class_e         cls   [NUM_OPS];
    res_kind_e         kind;

    assign words[OP_X] = opnd_x;
    assign words[OP_Y] = opnd_y;
    assign words[OP_Z] = opnd_z;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_cls
        fma_opnd_classify #(
            .EXP_W (EXP_W),
            .MAN_W (MAN_W)
        ) u_cls (
            .word_i (words[g]),
            .cls_o  (cls[g])
        );
    end

    fma_case_select u_sel (
        .cls_x_i (cls[OP_X]),
        .cls_y_i (cls[OP_Y]),
        .cls_z_i (cls[OP_Z]),
        .kind_o  (kind)
    );

    fma_result_build #(
        .EXP_W (EXP_W),
        .MAN_W (MAN_W)
    ) u_build (
        .kind_i    (kind),
        .x_i       (opnd_x),
        .y_i       (opnd_y),
        .z_i       (opnd_z),
        .valid_o   (spec_valid),
        .word_o    (spec_word),
        .invalid_o (spec_invalid)
    );

    assign cls_x = cls[OP_X];
    assign cls_y = cls[OP_Y];
    assign cls_z = cls[OP_Z];

endmodule

// File: rtl/fma_rsv_checker.sv
module fma_rsv_checker #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int WORD_W = 1 + EXP_W + MAN_W
) (
    input logic [WORD_W-1:0] opnd_x,
    input logic [WORD_W-1:0] opnd_y,
    input logic [WORD_W-1:0] opnd_z,
    input logic              spec_valid,
    input logic [WORD_W-1:0] spec_word,
    input logic              spec_invalid,
    input logic [2:0]        cls_x,
    input logic [2:0]        cls_y,
    input logic [2:0]        cls_z
);
    localparam logic [WORD_W-1:0] QBIT = WORD_W'(1) << (MAN_W - 1);

    always_comb begin
        // R1: a zero class means every bit below the sign is clear
        if (cls_x == 3'd0)
            p_zero_class_r1: assert (opnd_x[WORD_W-2:0] == '0)
                else $error("zero class on nonzero x");
        // R2: a signaling addend always yields its quieted copy with invalid
        if (cls_z == 3'd5)
            p_snan_addend_r2: assert (spec_valid && spec_invalid &&
                                      spec_word == (opnd_z | QBIT))
                else $error("signaling addend not resolved");
        // R3: a signaling multiplicand raises invalid
        if (cls_x == 3'd5 || cls_y == 3'd5)
            p_snan_mult_r3: assert (spec_valid && spec_invalid)
                else $error("signaling multiplicand without invalid");
        // R4: a quiet x with no signaling operand is passed through
        if (cls_x == 3'd4 && cls_y != 3'd5 && cls_z != 3'd5)
            p_qnan_x_r4: assert (spec_valid && !spec_invalid && spec_word == opnd_x)
                else $error("quiet x not passed");
        // R5: any raised invalid yields a quiet NaN word
        if (spec_invalid)
            p_invalid_nan_r5: assert (spec_word[WORD_W-2:MAN_W] == '1 &&
                                      (spec_word & QBIT) != '0)
                else $error("invalid without quiet NaN");
        // R9: handing off to the datapath carries no result and no flag
        if (!spec_valid)
            p_datapath_clean_r9: assert (spec_word == '0 && !spec_invalid &&
                                         cls_z != 3'd4 && cls_z != 3'd3)
                else $error("datapath hand-off not clean");
    end

endmodule

bind fma_special_resolver fma_rsv_checker #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W)
) u_rsv_checker (
    .opnd_x       (opnd_x),
    .opnd_y       (opnd_y),
    .opnd_z       (opnd_z),
    .spec_valid   (spec_valid),
    .spec_word    (spec_word),
    .spec_invalid (spec_invalid),
    .cls_x        (cls_x),
    .cls_y        (cls_y),
    .cls_z        (cls_z)
);

// File: tb/test_fma_special_resolver.sv
module test_fma_special_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_x = '0, opnd_y = '0, opnd_z = '0;
    logic        spec_valid, spec_invalid;
    logic [31:0] spec_word;
    logic [2:0]  cls_x, cls_y, cls_z;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_special_resolver i_fma_special_resolver (
        .opnd_x (opnd_x), .opnd_y (opnd_y), .opnd_z (opnd_z),
        .spec_valid (spec_valid), .spec_word (spec_word),
        .spec_invalid (spec_invalid),
        .cls_x (cls_x), .cls_y (cls_y), .cls_z (cls_z)
    );

    // R1 class codes: 0 zero, 1 normal, 2 denormal, 3 inf, 4 quiet, 5 signaling
    function automatic int class_of(input logic [31:0] w);
        int e = int'(w[30:23]);
        if (e == 0) return (w[22:0] == 0) ? 0 : 2;
        if (e == 255) begin
            if (w[22:0] == 0) return 3;
            return w[22] ? 4 : 5;
        end
        return 1;
    endfunction

    function automatic logic [31:0] inf_word(input logic s);
        return {s, 8'hFF, 23'd0};
    endfunction

    task automatic model(input logic [31:0] x, y, z,
                         output logic v, output logic [31:0] w,
                         output logic inv, output string req);
        int cx = class_of(x);
        int cy = class_of(y);
        int cz = class_of(z);
        v = 1; inv = 0; w = 0;
        if (cz == 5) begin w = z | 32'h0040_0000; inv = 1; req = "R2"; end
        else if (cx == 5) begin w = x | 32'h0040_0000; inv = 1; req = "R3"; end
        else if (cy == 5) begin w = y | 32'h0040_0000; inv = 1; req = "R3"; end
        else if (cx == 4) begin w = x; req = "R4"; end
        else if (cy == 4) begin w = y; req = "R4"; end
        else if ((cx == 3 && cy == 0) || (cx == 0 && cy == 3)) begin
            req = "R5";
            if (cz == 4) w = z;
            else begin w = 32'h7FC0_0000; inv = 1; end
        end else if (cx == 3 || cy == 3) begin
            req = "R6";
            w = (cz == 4) ? z : inf_word(x[31] ^ y[31]);
        end else if (cx == 0 || cy == 0) begin
            req = "R7";
            w = (cz == 3) ? inf_word(z[31]) : z;
        end else if (cz == 4 || cz == 3) begin
            req = (cx == 2 || cy == 2) ? "R10" : "R8";
            w = (cz == 4) ? z : inf_word(z[31]);
        end else begin
            req = (cx == 2 || cy == 2) ? "R10" : "R9";
            v = 0;
        end
    endtask

    function automatic logic [31:0] make_op(input int cls);
        logic [31:0] r = $urandom;
        logic [22:0] m = r[22:0];
        case (cls)
            0: return {r[31], 31'd0};
            1: return {r[31], 8'(1 + ($urandom % 254)), m};
            2: return {r[31], 8'd0, (m == 0) ? 23'd1 : m};
            3: return {r[31], 8'hFF, 23'd0};
            4: return {r[31], 8'hFF, 1'b1, m[21:0]};
            default: return {r[31], 8'hFF, 1'b0, (m[21:0] == 0) ? 22'd5 : m[21:0]};
        endcase
    endfunction

    task automatic apply(input logic [31:0] x, y, z);
        logic ev, einv;
        logic [31:0] ew;
        string req;
        @(posedge clk);
        #1;
        opnd_x = x; opnd_y = y; opnd_z = z;
        @(negedge clk);
        model(x, y, z, ev, ew, einv, req);
        checks++;
        if (spec_valid !== ev || spec_word !== ew || spec_invalid !== einv) begin
            failures++;
            $display("FAIL %s x=%h y=%h z=%h actual v=%b w=%h inv=%b expected v=%b w=%h inv=%b",
                     req, x, y, z, spec_valid, spec_word, spec_invalid, ev, ew, einv);
        end
        checks++;
        if (int'(cls_x) != class_of(x) || int'(cls_y) != class_of(y) ||
            int'(cls_z) != class_of(z)) begin
            failures++;
            $display("FAIL R1 classes actual %0d %0d %0d expected %0d %0d %0d",
                     cls_x, cls_y, cls_z, class_of(x), class_of(y), class_of(z));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state: all-zero operands, zero product returns +0 addend (R7)
        apply(32'h0, 32'h0, 32'h0);
        // R2: signaling addend beats signaling multiplicands
        apply(32'h7F80_0001, 32'hFF80_0002, 32'hFF81_2345);
        // R3: both multiplicands signaling -> x quieted
        apply(32'hFFA0_0001, 32'h7F80_0003, 32'h3F80_0000);
        // R3: quiet x, signaling y -> y quieted
        apply(32'h7FC0_0001, 32'h7F80_0007, 32'h7FC0_0000);
        // R4: both quiet -> x; quiet y beats quiet addend
        apply(32'hFFC0_1111, 32'h7FC0_2222, 32'h7FC0_3333);
        apply(32'h3F80_0000, 32'h7FD0_0000, 32'hFFC0_0009);
        // R5: inf x 0 with quiet addend / normal addend
        apply(32'h7F80_0000, 32'h8000_0000, 32'h7FC0_ABCD);
        apply(32'h0000_0000, 32'hFF80_0000, 32'h4000_0000);
        // R6: infinite product against opposite-sign infinite addend
        apply(32'hFF80_0000, 32'h4040_0000, 32'h7F80_0000);
        apply(32'hFF80_0000, 32'hFF80_0000, 32'hFFC0_0000);
        // R7: zero product with denormal / negative infinite addend
        apply(32'h8000_0000, 32'h0000_0001, 32'h0000_0123);
        apply(32'h0000_0000, 32'h3F80_0000, 32'hFF80_0000);
        // R8: finite product with infinite and quiet addends
        apply(32'h3F80_0000, 32'hC000_0000, 32'hFF80_0000);
        apply(32'h3F80_0000, 32'hC000_0000, 32'h7FC0_0005);
        // R9 and R10: datapath, denormal multiplicand is nonzero
        apply(32'h3F80_0000, 32'h4000_0000, 32'h4040_0000);
        apply(32'h0000_0001, 32'h8040_0000, 32'h0000_0000);
        for (int i = 0; i < N_RANDOM; i++) begin
            apply(make_op(int'($urandom % 6)), make_op(int'($urandom % 6)),
                  make_op(int'($urandom % 6)));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule